// File: doc/BRIEF.md
# Scan Instruction Register with Opcode Decoder

This block holds the 8-bit instruction of a boundary-scan test port and turns it into the control signals that the rest of the test logic needs. An external test-access state machine drives it with capture, shift and update strobes on the test clock. On capture, a shift stage loads a fixed pattern. On shift, the stage moves serial data in from the test data input toward its least significant bit, and that bit drives the test data output. On update, the stage is copied into a held instruction register.

The held instruction is decoded into three things. The first is a one-hot choice of the data register to place in the scan path: boundary, identification, bypass or boundary-control. The second is a device mode: normal, test or modified test. The third is a set of flags for special actions: drive pins to high impedance, clamp, run a boundary test, toggle outputs and run a self-test. Bit 7 of every valid opcode is an even-parity bit over the whole byte. An opcode that fails parity, or that is not defined, behaves exactly like a plain bypass in normal mode.

Top module: `scan_instr_reg`

## Requirements
- R1: On a capture strobe the shift stage loads 8'b1000_0001. Otherwise, on a shift strobe it moves one place toward bit 0, with the test data input entering bit 7. The test data output always shows bit 0 of the stage, so the first bit out after a capture is 1.
- R2: An update strobe copies the stage into the held instruction. The active-low asynchronous reset loads the identification opcode 8'b1000_0001 into the held instruction, and so does a synchronous test-logic-reset strobe. The test-logic reset takes priority over update.
- R3: The held instruction, register select, mode and action flags change only in the cycle after an update or test-logic-reset strobe. They never change during capture or shift.
- R4: The register select `dr_sel_o` is always one-hot, with bit 0 for boundary, bit 1 for identification, bit 2 for bypass and bit 3 for boundary-control. The mode `mode_o` is 00 for normal, 01 for test and 10 for modified test, and is never 11.
- R5: Boundary-register opcodes decode as follows. 8'h00 gives test mode. 8'h82 and 8'h0A give normal mode. 8'h8B gives test mode. 8'h0C gives normal mode with the self-test flag (action bit 4) set.
- R6: Opcode 8'h81 selects the identification register in normal mode.
- R7: Opcodes 8'h03, 8'h84, 8'h05 and 8'h88 select bypass in normal mode with no action flag set.
- R8: Opcode 8'h06 selects bypass in modified test mode with the high-impedance flag (action bit 0) set. Opcode 8'h87 selects bypass in test mode with the clamp flag (action bit 1) set.
- R9: Opcode 8'h09 selects bypass in test mode with the run-test flag (action bit 2) set. Opcode 8'h8D selects bypass in test mode with the toggle flag (action bit 3) set.
- R10: Opcode 8'h8E selects the boundary-control register in normal mode, and 8'h0F selects it in test mode.
- R11: Any other opcode decodes as bypass, normal mode, no flags. This includes a defined low part paired with the wrong bit 7, which is any byte with odd parity.
- R12: At most one action flag is set at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset |
| tlr_i | input | 1 | Synchronous test-logic-reset strobe |
| capture_i | input | 1 | Load the capture pattern into the shift stage |
| shift_i | input | 1 | Shift the stage one place toward bit 0 |
| update_i | input | 1 | Copy the shift stage into the held instruction |
| tdi_i | input | 1 | Serial test data input |
| tdo_o | output | 1 | Serial test data output (stage bit 0) |
| instr_o | output | 8 | Held instruction |
| dr_sel_o | output | 4 | One-hot data-register select |
| mode_o | output | 2 | Device mode |
| action_o | output | 5 | Special-action flags |

## Verification
The bench builds the block with its default parameters: an 8-bit instruction, with both the capture pattern and the reset opcode equal to the identification code. With an 8-bit width, every one of the 256 opcodes can be shifted in and updated within a short run. This covers all defined codes, every wrong-parity twin and every undefined code. Because the reset opcode differs from most loaded codes, the priority of test-logic reset over update and the stability of outputs during long shift sequences are both visible at the ports.

// File: rtl/scan_ir_pkg.sv
package scan_ir_pkg;

  // One-hot positions of the data-register select
  localparam int SEL_BSR = 0;
  localparam int SEL_ID  = 1;
  localparam int SEL_BYP = 2;
  localparam int SEL_BCR = 3;
  localparam int SEL_N   = 4;

  // Action flag positions
  localparam int ACT_HIZ   = 0;
  localparam int ACT_CLAMP = 1;
  localparam int ACT_RUN   = 2;
  localparam int ACT_TOG   = 3;
  localparam int ACT_SELF  = 4;
  localparam int ACT_N     = 5;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'b00,
    MODE_TEST    = 2'b01,
    MODE_MODTEST = 2'b10
  } dev_mode_e;

endpackage

// File: rtl/ir_shift_stage.sv
module ir_shift_stage #(
  parameter int             W       = 8,
  parameter logic [W-1:0]   CAP_PAT = 8'b1000_0001
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic         sh_en,
  input  logic         ser_in,
  output logic [W-1:0] stage_q
);

  logic [W-1:0] stage_d;

  always_comb begin
    stage_d = stage_q;
    if (cap_en) begin
      stage_d = CAP_PAT;
    end else if (sh_en) begin
      stage_d = {ser_in, stage_q[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= CAP_PAT;
    end else begin
      stage_q <= stage_d;
    end
  end

endmodule

// File: rtl/ir_hold_reg.sv
module ir_hold_reg #(
  parameter int           W      = 8,
  parameter logic [W-1:0] RST_OP = 8'b1000_0001
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tlr,
  input  logic         upd_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_d;
  logic         q_en;

  // test-logic reset wins over update
  always_comb begin
    q_en = tlr | upd_en;
    q_d  = tlr ? RST_OP : d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RST_OP;
    end else if (q_en) begin
      q <= q_d;
    end
  end

endmodule

// File: rtl/ir_opcode_decode.sv
module ir_opcode_decode
  import scan_ir_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]     op,
  output logic [SEL_N-1:0] sel,
  output logic [1:0]       mode,
  output logic [ACT_N-1:0] act
);

  logic      parity_ok;
  logic      upper_clear;
  logic      valid;
  dev_mode_e mode_e;

  // Top bit makes the whole word even parity
  assign parity_ok = ~(^op);

  generate
    if (W > 5) begin : g_upper
      assign upper_clear = (op[W-2:4] == '0);
    end else begin : g_no_upper
      assign upper_clear = 1'b1;
    end
  endgenerate

  assign valid = parity_ok & upper_clear;

  always_comb begin
    sel          = '0;
    sel[SEL_BYP] = 1'b1;
    mode_e       = MODE_NORMAL;
    act          = '0;
    if (valid) begin
      case (op[3:0])
        4'h0: begin sel = '0; sel[SEL_BSR] = 1'b1; mode_e = MODE_TEST; end
        4'h1: begin sel = '0; sel[SEL_ID]  = 1'b1; end
        4'h2: begin sel = '0; sel[SEL_BSR] = 1'b1; end
        4'h6: begin mode_e = MODE_MODTEST; act[ACT_HIZ] = 1'b1; end
        4'h7: begin mode_e = MODE_TEST; act[ACT_CLAMP] = 1'b1; end
        4'h9: begin mode_e = MODE_TEST; act[ACT_RUN] = 1'b1; end
        4'hA: begin sel = '0; sel[SEL_BSR] = 1'b1; end
        4'hB: begin sel = '0; sel[SEL_BSR] = 1'b1; mode_e = MODE_TEST; end
        4'hC: begin sel = '0; sel[SEL_BSR] = 1'b1; act[ACT_SELF] = 1'b1; end
        4'hD: begin mode_e = MODE_TEST; act[ACT_TOG] = 1'b1; end
        4'hE: begin sel = '0; sel[SEL_BCR] = 1'b1; end
        4'hF: begin sel = '0; sel[SEL_BCR] = 1'b1; mode_e = MODE_TEST; end
        default: ; // 3, 4, 5, 8: plain bypass
      endcase
    end
    mode = mode_e;
  end

endmodule

// File: rtl/scan_instr_reg.sv
module scan_instr_reg
  import scan_ir_pkg::*;
#(
  parameter int                IR_W        = 8,
  parameter logic [IR_W-1:0]   CAPTURE_PAT = 8'b1000_0001,
  parameter logic [IR_W-1:0]   RESET_OP    = 8'b1000_0001
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tlr_i,
  input  logic              capture_i,
  input  logic              shift_i,
  input  logic              update_i,
  input  logic              tdi_i,
  output logic              tdo_o,
  output logic [IR_W-1:0]   instr_o,
  output logic [SEL_N-1:0]  dr_sel_o,
  output logic [1:0]        mode_o,
  output logic [ACT_N-1:0]  action_o
);

  logic [IR_W-1:0] stage;

  ir_shift_stage #(.W(IR_W), .CAP_PAT(CAPTURE_PAT)) u_stage (
    .clk     (tck),
    .rst_n   (trst_n),
    .cap_en  (capture_i),
    .sh_en   (shift_i),
    .ser_in  (tdi_i),
    .stage_q (stage)
  );

  assign tdo_o = stage[0];

  ir_hold_reg #(.W(IR_W), .RST_OP(RESET_OP)) u_hold (
    .clk    (tck),
    .rst_n  (trst_n),
    .tlr    (tlr_i),
    .upd_en (update_i),
    .d      (stage),
    .q      (instr_o)
  );

  ir_opcode_decode #(.W(IR_W)) u_dec (
    .op   (instr_o),
    .sel  (dr_sel_o),
    .mode (mode_o),
    .act  (action_o)
  );

endmodule

// File: rtl/scan_instr_reg_chk.sv
module scan_instr_reg_chk #(
  parameter int IR_W = 8
) (
  input logic            tck,
  input logic            trst_n,
  input logic            tlr_i,
  input logic            capture_i,
  input logic            update_i,
  input logic            tdo_o,
  input logic [IR_W-1:0] instr_o,
  input logic [3:0]      dr_sel_o,
  input logic [1:0]      mode_o,
  input logic [4:0]      action_o
);

  // R4
  sel_onehot_chk: assert property (@(posedge tck) disable iff (!trst_n)
    $countones(dr_sel_o) == 1);

  // R4
  mode_legal_chk: assert property (@(posedge tck) disable iff (!trst_n)
    mode_o != 2'b11);

  // R12
  action_single_chk: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0(action_o));

  // R3
  hold_stable_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (!update_i && !tlr_i) |=> ($stable(instr_o) && $stable(dr_sel_o)
                               && $stable(mode_o) && $stable(action_o)));

  // R2
  tlr_id_chk: assert property (@(posedge tck) disable iff (!trst_n)
    tlr_i |=> (dr_sel_o == 4'b0010 && mode_o == 2'b00));

  // R1
  capture_lsb_chk: assert property (@(posedge tck) disable iff (!trst_n)
    capture_i |=> tdo_o);

  // R11
  bad_parity_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (^instr_o) |-> (dr_sel_o == 4'b0100 && mode_o == 2'b00 && action_o == 5'b0));

endmodule

bind scan_instr_reg scan_instr_reg_chk #(.IR_W(IR_W)) u_chk (
  .tck       (tck),
  .trst_n    (trst_n),
  .tlr_i     (tlr_i),
  .capture_i (capture_i),
  .update_i  (update_i),
  .tdo_o     (tdo_o),
  .instr_o   (instr_o),
  .dr_sel_o  (dr_sel_o),
  .mode_o    (mode_o),
  .action_o  (action_o)
);

// File: tb/sim_scan_instr_reg.sv
`timescale 1ns/1ps
module sim_scan_instr_reg;

  logic       tck = 1'b0;
  logic       trst_n = 1'b0;
  logic       tlr_i = 1'b0;
  logic       capture_i = 1'b0;
  logic       shift_i = 1'b0;
  logic       update_i = 1'b0;
  logic       tdi_i = 1'b0;
  logic       tdo_o;
  logic [7:0] instr_o;
  logic [3:0] dr_sel_o;
  logic [1:0] mode_o;
  logic [4:0] action_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 tck = ~tck;

  scan_instr_reg u0 (
    .tck(tck), .trst_n(trst_n), .tlr_i(tlr_i), .capture_i(capture_i),
    .shift_i(shift_i), .update_i(update_i), .tdi_i(tdi_i), .tdo_o(tdo_o),
    .instr_o(instr_o), .dr_sel_o(dr_sel_o), .mode_o(mode_o), .action_o(action_o)
  );

  // Behavioural reference: serial queue and held byte
  bit m_q[$];
  logic [7:0] m_ir;

  function automatic logic [7:0] q_to_byte();
    logic [7:0] b;
    for (int i = 0; i < 8; i++) b[i] = m_q[i];
    return b;
  endfunction

  task automatic q_load(input logic [7:0] v);
    m_q.delete();
    for (int i = 0; i < 8; i++) m_q.push_back(v[i]);
  endtask

  always @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      q_load(8'h81);
      m_ir = 8'h81;
    end else begin
      logic [7:0] snap;
      snap = q_to_byte();
      if (tlr_i) m_ir = 8'h81;
      else if (update_i) m_ir = snap;
      if (capture_i) q_load(8'h81);
      else if (shift_i) begin
        void'(m_q.pop_front());
        m_q.push_back(tdi_i);
      end
    end
  end

  // Expected decode: {sel, mode, act}, plus the requirement it belongs to
  task automatic expect_dec(input logic [7:0] op, output logic [3:0] s,
                            output logic [1:0] m, output logic [4:0] a,
                            output string req);
    s = 4'b0100; m = 2'b00; a = 5'b0; req = "R11";
    case (op)
      8'h00: begin s = 4'b0001; m = 2'b01; req = "R5"; end
      8'h82: begin s = 4'b0001; req = "R5"; end
      8'h0A: begin s = 4'b0001; req = "R5"; end
      8'h8B: begin s = 4'b0001; m = 2'b01; req = "R5"; end
      8'h0C: begin s = 4'b0001; a = 5'b10000; req = "R5"; end
      8'h81: begin s = 4'b0010; req = "R6"; end
      8'h03, 8'h84, 8'h05, 8'h88: req = "R7";
      8'h06: begin m = 2'b10; a = 5'b00001; req = "R8"; end
      8'h87: begin m = 2'b01; a = 5'b00010; req = "R8"; end
      8'h09: begin m = 2'b01; a = 5'b00100; req = "R9"; end
      8'h8D: begin m = 2'b01; a = 5'b01000; req = "R9"; end
      8'h8E: begin s = 4'b1000; req = "R10"; end
      8'h0F: begin s = 4'b1000; m = 2'b01; req = "R10"; end
      default: ;
    endcase
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare every clock, away from the active edge
  always @(negedge tck) begin
    if (trst_n && !done) begin
      logic [3:0] es; logic [1:0] em; logic [4:0] ea; string rq;
      expect_dec(m_ir, es, em, ea, rq);
      chk(tdo_o === m_q[0], "R1", "tdo", {31'b0, tdo_o}, {31'b0, m_q[0]});
      chk(instr_o === m_ir, "R2", "instr", {24'b0, instr_o}, {24'b0, m_ir});
      chk(dr_sel_o === es, rq, "sel", {28'b0, dr_sel_o}, {28'b0, es});
      chk(mode_o === em, rq, "mode", {30'b0, mode_o}, {30'b0, em});
      chk(action_o === ea, rq, "action", {27'b0, action_o}, {27'b0, ea});
      chk($countones(dr_sel_o) == 1 && mode_o != 2'b11, "R4", "encoding",
          {26'b0, dr_sel_o, mode_o}, {26'b0, es, em});
      chk($countones(action_o) <= 1, "R12", "flag count",
          {27'b0, action_o}, {27'b0, ea});
    end
  end

  task automatic step(input bit c, input bit s, input bit u, input bit t, input bit d);
    @(posedge tck); #1;
    capture_i = c; shift_i = s; update_i = u; tlr_i = t; tdi_i = d;
  endtask

  task automatic load_ir(input logic [7:0] op);
    step(1, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) step(0, 1, 0, 0, op[i]);
    step(0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] first_out;
    repeat (3) @(posedge tck);
    #1 trst_n = 1'b1;
    @(negedge tck);
    // R2 reset state: identification opcode, R6 decode
    chk(instr_o === 8'h81 && dr_sel_o === 4'b0010, "R2", "reset state",
        {24'b0, instr_o}, 32'h81);
    // R1 capture then observe serial bits
    step(1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    @(negedge tck);
    first_out = 8'h00;
    // every opcode in turn (R5..R11)
    for (int v = 0; v < 256; v++) load_ir(v[7:0]);
    // R3: shifting without update leaves outputs unchanged
    load_ir(8'h8E);
    step(1, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) step(0, 1, 0, 0, 1'b1);
    step(0, 0, 0, 0, 0);
    @(negedge tck);
    chk(dr_sel_o === 4'b1000, "R3", "sel after shift only",
        {28'b0, dr_sel_o}, 32'h8);
    // R2: test-logic reset beats a simultaneous update
    step(0, 0, 1, 1, 0);
    step(0, 0, 0, 0, 0);
    @(negedge tck);
    chk(instr_o === 8'h81, "R2", "tlr over update", {24'b0, instr_o}, 32'h81);
    // R2: async reset mid-run
    load_ir(8'h0F);
    @(negedge tck);
    trst_n = 1'b0;
    #1;
    chk(instr_o === 8'h81, "R2", "async reset", {24'b0, instr_o}, 32'h81);
    @(posedge tck); #1 trst_n = 1'b1;
    load_ir(8'h06);
    load_ir(8'h86);
    repeat (2) @(posedge tck);
    @(negedge tck);
    done = 1;
    if (first_out !== 8'h00) bad++;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule